// File: doc/BRIEF.md
# Spare-Row Wordline Redirector

This block sits between the row decoders of a two-port SRAM and its wordline drivers. It turns the write-port and read-port row addresses into one-hot wordline enables. A main row that the power-on self-test has flagged as faulty is never driven. Any access to that row raises a spare wordline instead. The main array of 2^n rows is cut into 2^k equal groups, and each group has a single dedicated spare row.

Redirection needs no search of a fault table. Each row's fault flag gates its own decoded select line. The same flag, combined with the decoded selects of its group, produces that group's spare enable. The two ports are handled by separate copies of the logic, so each port is redirected on its own address. All outputs are registered and appear one clock after the request. A status output reports when some group has more faulty rows than its single spare can cover.

Top module: `spare_row_redirect`

## Requirements
- R1: While rst_ni is low, every wordline output, every spare output and unrepairable_o are 0, and they go to 0 at once when rst_ni falls.
- R2: When a port's enable is 0, none of that port's main or spare wordlines assert in the following cycle.
- R3: An enabled access to an unflagged row r raises bit r of that port's main wordline vector exactly one clock later, with all of that port's spare bits low.
- R4: An enabled access to a flagged row r leaves every main wordline of that port low and raises that port's spare bit b, where b is the value of the upper BLK_AW bits of r (rows b*2^(ROW_AW-BLK_AW) to (b+1)*2^(ROW_AW-BLK_AW)-1 form group b).
- R5: The write port and read port are redirected independently in the same cycle, each according to its own address and enable.
- R6: A group with no flagged row never asserts its spare bit on either port.
- R7: unrepairable_o is 1 one clock after the fault flags of any single group hold two or more set bits, and 0 when every group has at most one.
- R8: At most one wordline, main or spare, is active per port in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write port access request |
| wr_addr_i | input | ROW_AW | Write port row address |
| rd_en_i | input | 1 | Read port access request |
| rd_addr_i | input | ROW_AW | Read port row address |
| fault_i | input | 2^ROW_AW | Per-row faulty flags from self-test, bit r for row r |
| wr_wl_o | output | 2^ROW_AW | Write-port main wordline enables |
| rd_wl_o | output | 2^ROW_AW | Read-port main wordline enables |
| wr_spare_o | output | 2^BLK_AW | Write-port spare wordline enables, one per group |
| rd_spare_o | output | 2^BLK_AW | Read-port spare wordline enables, one per group |
| unrepairable_o | output | 1 | Some group has more than one flagged row |

## Verification
The assertions assume that fault_i is steady or changes only between accesses, because every check relates a registered output to the fault flags and addresses sampled on the previous edge. They also assume that rst_ni is held low through the first edges. The stimulus changes the inputs only at falling edges, including the fault pattern, and it holds reset for several cycles before the first request. It covers flagged and unflagged rows in every group, disabled ports, both ports active on different groups, and groups with zero, one and several flags.

// File: rtl/redir_pkg.sv
package redir_pkg;
  parameter int unsigned DEF_ROW_AW = 5;
  parameter int unsigned DEF_BLK_AW = 2;
  localparam int unsigned NUM_PORTS = 2;
  typedef enum logic {PORT_WR = 1'b0, PORT_RD = 1'b1} port_e;
endpackage

// File: rtl/redir_decode.sv
module redir_decode #(
  parameter int unsigned ROW_AW = redir_pkg::DEF_ROW_AW,
  localparam int unsigned ROWS = 1 << ROW_AW
) (
  input  logic              en_i,
  input  logic [ROW_AW-1:0] addr_i,
  output logic [ROWS-1:0]   sel_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign sel_o[r] = en_i && (addr_i == ROW_AW'(r));
  end
endmodule

// File: rtl/redir_port.sv
module redir_port #(
  parameter int unsigned ROW_AW = redir_pkg::DEF_ROW_AW,
  parameter int unsigned BLK_AW = redir_pkg::DEF_BLK_AW,
  localparam int unsigned ROWS = 1 << ROW_AW,
  localparam int unsigned BLKS = 1 << BLK_AW,
  localparam int unsigned RPB  = ROWS / BLKS
) (
  input  logic [ROWS-1:0] sel_i,
  input  logic [ROWS-1:0] fault_i,
  output logic [ROWS-1:0] wl_o,
  output logic [BLKS-1:0] spare_o
);
  assign wl_o = sel_i & ~fault_i;

  // a group's spare follows any selected row in it that is flagged
  for (genvar b = 0; b < BLKS; b++) begin : g_blk
    assign spare_o[b] = |(sel_i[b*RPB +: RPB] & fault_i[b*RPB +: RPB]);
  end
endmodule

// File: rtl/redir_census.sv
module redir_census #(
  parameter int unsigned ROW_AW = redir_pkg::DEF_ROW_AW,
  parameter int unsigned BLK_AW = redir_pkg::DEF_BLK_AW,
  localparam int unsigned ROWS = 1 << ROW_AW,
  localparam int unsigned BLKS = 1 << BLK_AW,
  localparam int unsigned RPB  = ROWS / BLKS
) (
  input  logic [ROWS-1:0] fault_i,
  output logic            multi_o
);
  logic [BLKS-1:0] blk_multi;

  // x & (x-1) is nonzero only when x has two or more set bits
  for (genvar b = 0; b < BLKS; b++) begin : g_blk
    logic [RPB-1:0] slice;
    assign slice        = fault_i[b*RPB +: RPB];
    assign blk_multi[b] = |(slice & (slice - RPB'(1)));
  end

  assign multi_o = |blk_multi;
endmodule

// File: rtl/spare_row_redirect.sv
module spare_row_redirect #(
  parameter int unsigned ROW_AW = redir_pkg::DEF_ROW_AW,
  parameter int unsigned BLK_AW = redir_pkg::DEF_BLK_AW,
  localparam int unsigned ROWS = 1 << ROW_AW,
  localparam int unsigned BLKS = 1 << BLK_AW,
  localparam int unsigned RPB  = ROWS / BLKS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ROW_AW-1:0] wr_addr_i,
  input  logic              rd_en_i,
  input  logic [ROW_AW-1:0] rd_addr_i,
  input  logic [ROWS-1:0]   fault_i,
  output logic [ROWS-1:0]   wr_wl_o,
  output logic [ROWS-1:0]   rd_wl_o,
  output logic [BLKS-1:0]   wr_spare_o,
  output logic [BLKS-1:0]   rd_spare_o,
  output logic              unrepairable_o
);
  import redir_pkg::*;

  logic              port_en   [NUM_PORTS];
  logic [ROW_AW-1:0] port_addr [NUM_PORTS];
  logic [ROWS-1:0]   port_sel  [NUM_PORTS];
  logic [ROWS-1:0]   port_wl   [NUM_PORTS];
  logic [BLKS-1:0]   port_sp   [NUM_PORTS];
  logic              multi;

  assign port_en[PORT_WR]   = wr_en_i;
  assign port_addr[PORT_WR] = wr_addr_i;
  assign port_en[PORT_RD]   = rd_en_i;
  assign port_addr[PORT_RD] = rd_addr_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    redir_decode #(.ROW_AW(ROW_AW)) u_dec (
      .en_i  (port_en[p]),
      .addr_i(port_addr[p]),
      .sel_o (port_sel[p])
    );
    redir_port #(.ROW_AW(ROW_AW), .BLK_AW(BLK_AW)) u_port (
      .sel_i  (port_sel[p]),
      .fault_i(fault_i),
      .wl_o   (port_wl[p]),
      .spare_o(port_sp[p])
    );
  end

  redir_census #(.ROW_AW(ROW_AW), .BLK_AW(BLK_AW)) u_census (
    .fault_i(fault_i),
    .multi_o(multi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_wl_o        <= '0;
      rd_wl_o        <= '0;
      wr_spare_o     <= '0;
      rd_spare_o     <= '0;
      unrepairable_o <= 1'b0;
    end else begin
      wr_wl_o        <= port_wl[PORT_WR];
      rd_wl_o        <= port_wl[PORT_RD];
      wr_spare_o     <= port_sp[PORT_WR];
      rd_spare_o     <= port_sp[PORT_RD];
      unrepairable_o <= multi;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk_i) !rst_ni |-> (wr_wl_o == '0 && rd_wl_o == '0
                                    && wr_spare_o == '0 && rd_spare_o == '0 && !unrepairable_o));
  // R2
  wr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                !wr_en_i |=> (wr_wl_o == '0 && wr_spare_o == '0));
  // R2
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                !rd_en_i |=> (rd_wl_o == '0 && rd_spare_o == '0));
  // R4
  wr_flag_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                    (wr_wl_o & $past(fault_i)) == '0);
  // R4
  rd_flag_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                    (rd_wl_o & $past(fault_i)) == '0);
  // R8
  wr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                  $countones({wr_wl_o, wr_spare_o}) <= 1);
  // R8
  rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                  $countones({rd_wl_o, rd_spare_o}) <= 1);

  for (genvar b = 0; b < BLKS; b++) begin : g_blk_chk
    // R6
    spare_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_spare_o[b] || rd_spare_o[b]) |-> ($past(fault_i[b*RPB +: RPB]) != '0));
    // R7
    multi_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones(fault_i[b*RPB +: RPB]) > 1) |=> unrepairable_o);
  end
endmodule

// File: tb/spare_row_redirect_bench.sv
module spare_row_redirect_bench;
  localparam int unsigned AW = 5;
  localparam int unsigned KW = 2;
  localparam int unsigned ROWS = 1 << AW;
  localparam int unsigned BLKS = 1 << KW;
  localparam int unsigned NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [ROWS-1:0] fault = '0;
  logic [ROWS-1:0] wr_wl, rd_wl;
  logic [BLKS-1:0] wr_sp, rd_sp;
  logic unrep;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spare_row_redirect #(.ROW_AW(AW), .BLK_AW(KW)) u_spare_row_redirect (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
    .fault_i(fault), .wr_wl_o(wr_wl), .rd_wl_o(rd_wl),
    .wr_spare_o(wr_sp), .rd_spare_o(rd_sp), .unrepairable_o(unrep)
  );

  // expected main index 32 = none, spare index 4 = none
  typedef struct packed {
    logic        we;
    logic [4:0]  wa;
    logic        re;
    logic [4:0]  ra;
    logic [31:0] flt;
    logic [5:0]  ewm;
    logic [2:0]  ews;
    logic [5:0]  erm;
    logic [2:0]  ers;
    logic        eu;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd3,  1'b1, 5'd20, 32'h0000_0000, 6'd3,  3'd4, 6'd20, 3'd4, 1'b0},
    '{1'b1, 5'd3,  1'b1, 5'd20, 32'h0000_0008, 6'd32, 3'd0, 6'd20, 3'd4, 1'b0},
    '{1'b1, 5'd3,  1'b1, 5'd20, 32'h0010_0008, 6'd32, 3'd0, 6'd32, 3'd2, 1'b0},
    '{1'b1, 5'd4,  1'b1, 5'd21, 32'h0010_0008, 6'd4,  3'd4, 6'd21, 3'd4, 1'b0},
    '{1'b1, 5'd31, 1'b0, 5'd31, 32'h8000_0000, 6'd32, 3'd3, 6'd32, 3'd4, 1'b0},
    '{1'b0, 5'd31, 1'b1, 5'd31, 32'h8000_0000, 6'd32, 3'd4, 6'd32, 3'd3, 1'b0},
    '{1'b1, 5'd8,  1'b1, 5'd10, 32'h0000_0300, 6'd32, 3'd1, 6'd10, 3'd4, 1'b1},
    '{1'b1, 5'd16, 1'b1, 5'd25, 32'h0101_0101, 6'd32, 3'd2, 6'd25, 3'd4, 1'b0},
    '{1'b1, 5'd24, 1'b1, 5'd0,  32'h0101_0101, 6'd32, 3'd3, 6'd32, 3'd0, 1'b0},
    '{1'b1, 5'd5,  1'b1, 5'd30, 32'hFFFF_FFFF, 6'd32, 3'd0, 6'd32, 3'd3, 1'b1}
  };

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ROWS-1:0] main_hot(logic [5:0] idx);
    return (idx >= 6'(ROWS)) ? '0 : (ROWS'(1) << idx);
  endfunction

  function automatic logic [BLKS-1:0] sp_hot(logic [2:0] idx);
    return (idx >= 3'(BLKS)) ? '0 : (BLKS'(1) << idx);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1 reset state
    fault = 32'h0000_00FF;
    wr_en = 1'b1;
    rd_en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset wl", {wr_wl, rd_wl}, '0);
    check("R1", "reset spare/unrep", {wr_sp, rd_sp, unrep}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    wr_en = 1'b0;
    rd_en = 1'b0;
    fault = '0;

    // table: R2 R3 R4 R5 R7
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en = VEC[i].we; wr_addr = VEC[i].wa;
      rd_en = VEC[i].re; rd_addr = VEC[i].ra;
      fault = VEC[i].flt;
      @(posedge clk);
      #1;
      check("R3/R4/R5", $sformatf("v%0d wr_wl", i), 64'(wr_wl), 64'(main_hot(VEC[i].ewm)));
      check("R3/R4/R5", $sformatf("v%0d rd_wl", i), 64'(rd_wl), 64'(main_hot(VEC[i].erm)));
      check("R2/R4", $sformatf("v%0d wr_sp", i), 64'(wr_sp), 64'(sp_hot(VEC[i].ews)));
      check("R2/R4", $sformatf("v%0d rd_sp", i), 64'(rd_sp), 64'(sp_hot(VEC[i].ers)));
      check("R7", $sformatf("v%0d unrep", i), 64'(unrep), 64'(VEC[i].eu));
    end

    // R6: only row 3 flagged; rows of groups 1..3 never touch their spares
    for (int a = 8; a < ROWS; a++) begin
      @(negedge clk);
      fault = 32'h0000_0008;
      wr_en = 1'b1; wr_addr = AW'(a);
      rd_en = 1'b1; rd_addr = AW'(ROWS + 7 - a);
      @(posedge clk);
      #1;
      check("R6", $sformatf("a%0d spares", a), 64'({wr_sp, rd_sp}), '0);
      check("R3", $sformatf("a%0d wr_wl", a), 64'(wr_wl), 64'(main_hot(6'(a))));
    end

    // R8: all rows of group 0 flagged while accessing each of them
    for (int a = 0; a < 8; a++) begin
      @(negedge clk);
      fault = 32'h0000_00FF;
      wr_en = 1'b1; wr_addr = AW'(a);
      rd_en = 1'b1; rd_addr = AW'(a + 8);
      @(posedge clk);
      #1;
      check("R8", $sformatf("a%0d wr", a), 64'({wr_wl, wr_sp}), 64'({32'h0, 4'b0001}));
      check("R8", $sformatf("a%0d rd", a), 64'({rd_wl, rd_sp}), 64'({main_hot(6'(a + 8)), 4'b0000}));
    end

    // R1 asynchronous clear mid-run
    @(negedge clk);
    fault = 32'h0000_0300;
    wr_addr = 5'd8;
    @(posedge clk);
    #1;
    check("R7", "pre-reset unrep", 64'(unrep), 64'(1));
    rst_n = 1'b0;
    #1;
    check("R1", "async clear", 64'({wr_sp, rd_sp, unrep}), '0);
    check("R1", "async clear wl", {wr_wl, rd_wl}, '0);

    finish_run();
  end
endmodule